// File: doc/BRIEF.md
# Flag-Marking Pass Counter

This block is a small synchronous machine split into a three-state controller and a datapath. The datapath holds a 4-bit count register and two single-bit flags. A pulse on the start input, taken while the machine is idle, clears the count and the completion flag and begins a counting pass. During the pass the count advances on every clock. The tracking flag copies the second-lowest count bit on every clock. The pass ends once the second and third count bits are both set. The machine then spends one cycle in a finishing state, raises the completion flag and returns to idle.

Every operation that belongs to a state, together with its decisions, takes effect on a single clock edge. All decisions look at register values from before that edge. Starting from zero, a pass spends seven cycles counting, leaves the count at 7 and then spends one cycle finishing. The current state is exposed as three one-hot indicator outputs.

Top module: `asm_flag_counter`

## Requirements
- R1: A synchronous active-high reset puts the machine in the idle state and clears the count, the tracking flag and the completion flag.
- R2: In the idle state with start low, the machine stays idle and the count and both flags keep their values.
- R3: In the idle state with start high, the next edge clears the count, clears the completion flag, leaves the tracking flag unchanged and enters the counting state.
- R4: In the counting state the count increases by one on every clock, and the start input has no effect.
- R5: In the counting state the tracking flag takes, at each edge, the value that count bit 1 (the second-lowest bit, weight 2) held before that edge.
- R6: The counting state moves to the finishing state only when count bits 1 and 2 (weights 2 and 4) were both 1 before the edge. Otherwise it stays in the counting state.
- R7: The finishing state sets the completion flag, keeps the count and the tracking flag unchanged, and always returns to idle on the next edge, whatever the start input is.
- R8: A pass launched from idle spends exactly seven cycles in the counting state and reaches the finishing state with the count equal to 7.
- R9: Exactly one of the three state indicators (idle, counting, finishing) is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a pass when sampled high in the idle state |
| cnt | output | 4 | Count register value |
| trk_flag | output | 1 | Tracking flag, follows count bit 1 during counting |
| done_flag | output | 1 | Completion flag, set in the finishing state |
| st_idle | output | 1 | High while the machine is in the idle state |
| st_count | output | 1 | High while the machine is in the counting state |
| st_fin | output | 1 | High while the machine is in the finishing state |

## Verification
Random start pulses, sparse and dense, are mixed with long stretches of start held low. Together they show whether a launch happens only from idle. They also show whether a high start during counting or finishing is ignored. A stretch with start held high shows that a new pass begins right after the machine returns to idle. A synchronous reset asserted in the middle of a pass shows that reset wins over the counting logic. The length of every full pass and the count it ends with are measured. This separates a termination decision that uses the value before the edge from one that uses the value being written, and it shows whether the correct count bits were chosen.

// File: rtl/asm_flag_counter.sv
module asm_flag_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [CNT_W-1:0] cnt,
  output logic             trk_flag,
  output logic             done_flag,
  output logic             st_idle,
  output logic             st_count,
  output logic             st_fin
);
  localparam int TRK_BIT = 1;
  localparam int END_BIT = 2;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_COUNT = 2'b01,
    S_FIN   = 2'b11
  } state_t;

  state_t state, state_nx;

  logic cmd_clear, cmd_inc, cmd_set_done;
  logic at_end;

  assign at_end       = cnt[TRK_BIT] & cnt[END_BIT];
  assign cmd_clear    = (state == S_IDLE) & start;
  assign cmd_inc      = (state == S_COUNT);
  assign cmd_set_done = (state == S_FIN);

  always_comb begin
    case (state)
      S_IDLE:  state_nx = start  ? S_COUNT : S_IDLE;
      S_COUNT: state_nx = at_end ? S_FIN   : S_COUNT;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      trk_flag  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      state <= state_nx;
      if (cmd_clear)
        cnt <= '0;
      else if (cmd_inc)
        cnt <= cnt + 1'b1;
      if (cmd_inc)
        trk_flag <= cnt[TRK_BIT];
      if (cmd_clear)
        done_flag <= 1'b0;
      else if (cmd_set_done)
        done_flag <= 1'b1;
    end
  end

  assign st_idle  = (state == S_IDLE);
  assign st_count = (state == S_COUNT);
  assign st_fin   = (state == S_FIN);
endmodule

module asm_flag_counter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] cnt,
  input logic             trk_flag,
  input logic             done_flag,
  input logic             st_idle,
  input logic             st_count,
  input logic             st_fin
);
  // R9
  one_state_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({st_idle, st_count, st_fin}) == 1);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st_idle && !start |=> st_idle && $stable(cnt) && $stable(trk_flag) && $stable(done_flag));

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    st_idle && start |=> st_count && cnt == '0 && !done_flag && $stable(trk_flag));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    st_count |=> cnt == $past(cnt) + 1'b1);

  // R5
  trk_follow_chk: assert property (@(posedge clk) disable iff (rst)
    st_count |=> trk_flag == $past(cnt[1]));

  // R6
  stay_count_chk: assert property (@(posedge clk) disable iff (rst)
    st_count && !(cnt[1] && cnt[2]) |=> st_count);

  // R6
  leave_count_chk: assert property (@(posedge clk) disable iff (rst)
    st_count && cnt[1] && cnt[2] |=> st_fin);

  // R7
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    st_fin |=> st_idle && done_flag && $stable(cnt) && $stable(trk_flag));
endmodule

bind asm_flag_counter asm_flag_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/asm_flag_counter_test.sv
module asm_flag_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] cnt;
  logic       trk_flag, done_flag, st_idle, st_count, st_fin;

  int n_chk = 0;
  int n_bad = 0;

  // bench model: 0 idle, 1 counting, 2 finishing
  int         m_st = 0;
  logic [3:0] m_cnt = '0;
  logic       m_trk = 1'b0;
  logic       m_done = 1'b0;
  string      m_tag = "R1";
  int         run_len = 0;
  bit         run_valid = 1'b0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  asm_flag_counter uut (
    .clk(clk), .rst(rst), .start(start), .cnt(cnt),
    .trk_flag(trk_flag), .done_flag(done_flag),
    .st_idle(st_idle), .st_count(st_count), .st_fin(st_fin)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int state_code(input logic i, input logic c, input logic f);
    if ({i, c, f} == 3'b100) return 0;
    if ({i, c, f} == 3'b010) return 1;
    if ({i, c, f} == 3'b001) return 2;
    return 9;
  endfunction

  task automatic compare_all();
    chk("R9", "one-hot states", $countones({st_idle, st_count, st_fin}), 1);
    chk(m_tag, "state", state_code(st_idle, st_count, st_fin), m_st);
    chk(m_tag, "count", int'(cnt), int'(m_cnt));
    chk(m_tag == "R4" ? "R5" : m_tag, "tracking flag", int'(trk_flag), int'(m_trk));
    chk(m_tag, "done flag", int'(done_flag), int'(m_done));
    if (st_count) run_len++;
    if (st_fin && run_valid) begin
      chk("R8", "pass length", run_len, 7);
      chk("R8", "count at finish", int'(cnt), 7);
    end
    if (!st_count) begin
      run_valid = st_idle;
      run_len = 0;
    end
  endtask

  task automatic model_step(input logic r, input logic s);
    if (r) begin
      m_st = 0; m_cnt = '0; m_trk = 1'b0; m_done = 1'b0; m_tag = "R1";
    end else begin
      case (m_st)
        0: if (s) begin
             m_cnt = '0; m_done = 1'b0; m_st = 1; m_tag = "R3";
           end else m_tag = "R2";
        1: begin
             m_st = (m_cnt[1] && m_cnt[2]) ? 2 : 1;
             m_trk = m_cnt[1];
             m_cnt = m_cnt + 4'd1;
             m_tag = (m_st == 2) ? "R6" : "R4";
           end
        default: begin
             m_done = 1'b1; m_st = 0; m_tag = "R7";
           end
      endcase
    end
  endtask

  task automatic cycle(input logic r, input logic s);
    @(negedge clk);
    compare_all();
    model_step(r, s);
    rst = r;
    start = s;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "reset state", state_code(st_idle, st_count, st_fin), 0);
    chk("R1", "reset count", int'(cnt), 0);
    chk("R1", "reset flags", int'({trk_flag, done_flag}), 0);
    model_step(1'b0, 1'b0);
    rst = 1'b0;
    // R2 long idle stretch
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0);
    // directed single pass, then start held high
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 12; i++) cycle(1'b0, 1'b0);
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1);
    // mid-pass reset
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 15; i++) cycle(1'b0, 1'b0);
    // random phases: sparse and dense starts
    for (int i = 0; i < 3000; i++) begin
      logic s;
      s = (i < 1500) ? (($urandom % 16) == 0) : (($urandom % 2) == 0);
      cycle(($urandom % 500) == 0, s);
    end
    cycle(1'b0, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule